// File: doc/BRIEF.md
# Dual-Core Level Interrupt Aggregator

The block gathers thirty-two active-high, level-sensitive interrupt sources into one live status word. It drives four outputs: an ordinary interrupt line and a machine-check line for each of two processor cores. Every output has its own enable mask. An output stays high for as long as any source is both high and enabled in that output's mask. There is no acknowledge. A line falls only when the source drops or software clears the mask bit.

Software reaches the masks through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data, and read data that follows the address combinationally. Sources are asynchronous, so each passes through a two-flop synchroniser before it reaches the status word. Every output is registered. The block does not steer or arbitrate between outputs. One source may raise any number of outputs at once if its bit is enabled in several masks. A read-only priority register gives the number of the highest active source that core 0's interrupt mask lets through.

Top module: `irqagg_top`

## Requirements
- R1: The status register at offset 0x00 is read-only. Bit i shows the level of source i, taken through two synchronising flops: a change on a source appears in the status word after the second rising clock edge.
- R2: The interrupt masks for core 0 and core 1 are at offsets 0x10 and 0x14. The machine-check masks for core 0 and core 1 are at 0x18 and 0x1C. Each reads back exactly the 32-bit value last written to it.
- R3: While reset is active and just after it, all four masks read zero, the status word reads zero and all four outputs are low.
- R4: Each output is a flop that takes the OR of (status AND that output's mask). It changes on the first rising edge after the status word or the mask changes.
- R5: A mask bit of 1 passes the matching source to that output. A mask bit of 0 blocks it, and an output whose mask is all zero stays low.
- R6: A source enabled in several masks drives every one of those outputs high in the same cycle.
- R7: Outputs follow levels. An output stays high for as long as an enabled source stays high, with no acknowledge action. It falls one edge after its mask bit is cleared, or three edges after the source drops.
- R8: Reads of any offset other than 0x00, 0x10, 0x14, 0x18, 0x1C and 0x20 return zero. Writes to 0x00, to 0x20 or to any unmapped offset change no mask.
- R9: The register at offset 0x20 is read-only. It returns, in its low bits, the highest bit number set in (status AND core-0 interrupt mask), and 0 when no such bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq | input | 32 | Asynchronous level interrupt sources, active high |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_irq | output | 2 | Ordinary interrupt line per core |
| core_mchk | output | 2 | Machine-check line per core |

## Verification
The bench walks a single active source across all thirty-two positions against four masks that overlap in a known way, so each bit lands on a known set of outputs. A swapped or shifted mask, or a lost fan-out, therefore raises the wrong line. Pseudo-random source and mask sweeps check the priority register, with close attention to bit 0 and the all-clear case, which both read 0. If the priority logic picked the lowest bit, or used the wrong mask, it would return the wrong index here. Edge-exact checks of mask clearing and source removal catch a missing or extra pipeline stage. Writes to the status offset, the priority offset and stray offsets catch a decoder that lets a write reach a mask.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int unsigned REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_STATUS    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_IRQ_BASE  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_MCHK_BASE = 8'h18;
    localparam logic [REG_AW-1:0] OFS_TOPIDX    = 8'h20;
    localparam int unsigned       OFS_STRIDE    = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_IRQ,
        SEL_MCHK,
        SEL_TOPIDX
    } reg_sel_e;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= din;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned N_CORE = 2,
    parameter int unsigned DW     = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_SRC-1:0]                  status,
    input  logic [REG_AW-1:0]                 addr,
    input  logic                              wen,
    input  logic [DW-1:0]                     wdata,
    output logic [DW-1:0]                     rdata,
    output logic [N_CORE-1:0][N_SRC-1:0]      irq_mask,
    output logic [N_CORE-1:0][N_SRC-1:0]      mchk_mask
);

    localparam int unsigned CW = (N_CORE > 1) ? $clog2(N_CORE) : 1;
    localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    reg_sel_e          sel;
    logic [CW-1:0]     core_sel;
    logic [IW-1:0]     top_idx;
    logic [N_SRC-1:0]  prio_act;

    // Address decode
    always_comb begin
        sel      = SEL_NONE;
        core_sel = '0;
        if (addr == OFS_STATUS) begin
            sel = SEL_STATUS;
        end
        if (addr == OFS_TOPIDX) begin
            sel = SEL_TOPIDX;
        end
        for (int c = 0; c < N_CORE; c++) begin
            if (addr == OFS_IRQ_BASE + REG_AW'(OFS_STRIDE * c)) begin
                sel      = SEL_IRQ;
                core_sel = CW'(c);
            end
            if (addr == OFS_MCHK_BASE + REG_AW'(OFS_STRIDE * c)) begin
                sel      = SEL_MCHK;
                core_sel = CW'(c);
            end
        end
    end

    // Mask storage, one pair per core
    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_mask[c] <= '0;
            end else if (wen && sel == SEL_IRQ && core_sel == CW'(c)) begin
                irq_mask[c] <= wdata[N_SRC-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mchk_mask[c] <= '0;
            end else if (wen && sel == SEL_MCHK && core_sel == CW'(c)) begin
                mchk_mask[c] <= wdata[N_SRC-1:0];
            end
        end

        AST_IRQ_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wen && addr == OFS_IRQ_BASE + REG_AW'(OFS_STRIDE * c))
            |=> irq_mask[c] == $past(wdata[N_SRC-1:0])); // R2
        AST_MCHK_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wen && addr == OFS_MCHK_BASE + REG_AW'(OFS_STRIDE * c))
            |=> mchk_mask[c] == $past(wdata[N_SRC-1:0])); // R2
    end

    // Highest enabled source for core 0 interrupt line
    assign prio_act = status & irq_mask[0];

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (prio_act[i]) begin
                top_idx = IW'(i);
            end
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_STATUS: rdata = DW'(status);
            SEL_IRQ:    rdata = DW'(irq_mask[core_sel]);
            SEL_MCHK:   rdata = DW'(mchk_mask[core_sel]);
            SEL_TOPIDX: rdata = DW'(top_idx);
            SEL_NONE:   rdata = '0;
            default:    rdata = '0;
        endcase
    end

    AST_MASK_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (irq_mask == '0 && mchk_mask == '0)); // R3
    AST_STRAY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && (sel == SEL_NONE || sel == SEL_STATUS || sel == SEL_TOPIDX))
        |=> ($stable(irq_mask) && $stable(mchk_mask))); // R8
    AST_TOPIDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & irq_mask[0]) == '0 && addr == OFS_TOPIDX) |-> rdata == '0); // R9

endmodule

// File: rtl/irqagg_fanout.sv
module irqagg_fanout #(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned N_OUT = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_SRC-1:0]               status,
    input  logic [N_OUT-1:0][N_SRC-1:0]    mask,
    output logic [N_OUT-1:0]               line_q
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        logic hit;
        assign hit = |(status & mask[k]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q[k] <= 1'b0;
            end else begin
                line_q[k] <= hit;
            end
        end

        AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (mask[k] == '0) |=> !line_q[k]); // R5
        AST_IDLE_SOURCES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (status == '0) |=> !line_q[k]); // R7
    end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned N_CORE = 2,
    parameter int unsigned DW     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_irq,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_CORE-1:0] core_irq,
    output logic [N_CORE-1:0] core_mchk
);

    localparam int unsigned N_OUT = 2 * N_CORE;

    logic [N_SRC-1:0]                 status;
    logic [N_CORE-1:0][N_SRC-1:0]     irq_mask;
    logic [N_CORE-1:0][N_SRC-1:0]     mchk_mask;
    logic [N_OUT-1:0][N_SRC-1:0]      all_mask;
    logic [N_OUT-1:0]                 lines;

    irqagg_sync #(
        .WIDTH  (N_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src_irq),
        .dout  (status)
    );

    irqagg_regs #(
        .N_SRC  (N_SRC),
        .N_CORE (N_CORE),
        .DW     (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .status    (status),
        .addr      (bus_addr),
        .wen       (bus_wen),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .irq_mask  (irq_mask),
        .mchk_mask (mchk_mask)
    );

    for (genvar c = 0; c < N_CORE; c++) begin : g_pack
        assign all_mask[c]          = irq_mask[c];
        assign all_mask[N_CORE + c] = mchk_mask[c];
    end

    irqagg_fanout #(
        .N_SRC (N_SRC),
        .N_OUT (N_OUT)
    ) u_fanout (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .mask   (all_mask),
        .line_q (lines)
    );

    assign core_irq  = lines[N_CORE-1:0];
    assign core_mchk = lines[N_OUT-1:N_CORE];

    AST_RESET_LINES_LOW: assert property (@(posedge clk)
        !rst_n |-> (core_irq == '0 && core_mchk == '0)); // R3

endmodule

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src;
    logic [7:0]  addr;
    logic        wen;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [1:0]  core_irq;
    logic [1:0]  core_mchk;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;

    logic [31:0] shadow [4];
    logic [7:0]  mofs [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top u_irqagg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src),
        .bus_addr  (addr),
        .bus_wen   (wen),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .core_irq  (core_irq),
        .core_mchk (core_mchk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0; addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_mask(input int k, input logic [31:0] d);
        wr(mofs[k], d);
        shadow[k] = d;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] top_of(input logic [31:0] v);
        logic [31:0] r = 0;
        for (int i = 0; i < 32; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [3:0] exp_lines(input logic [31:0] s);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = |(s & shadow[k]);
        return r;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        rd(8'h00, d);
        check({tag, " R1 status"}, d, src);
        check({tag, " R4 R6 lines"}, {28'd0, core_mchk, core_irq}, {28'd0, exp_lines(src)});
        rd(8'h20, d);
        check({tag, " R9 topidx"}, d, top_of(src & shadow[0]));
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] lfsr;
        mofs[0] = 8'h10; mofs[1] = 8'h14; mofs[2] = 8'h18; mofs[3] = 8'h1C;
        for (int k = 0; k < 4; k++) shadow[k] = '0;
        rst_n = 1'b0; src = '0; addr = '0; wen = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        // R3: state during reset
        check("R3 lines in reset", {30'd0, core_irq | core_mchk}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            rd(mofs[k], d);
            check("R3 mask reset", d, 32'd0);
        end
        rd(8'h00, d);
        check("R3 status reset", d, 32'd0);
        check("R3 lines after reset", {28'd0, core_mchk, core_irq}, 32'd0);

        // R2: readback of distinct patterns
        set_mask(0, 32'h1234_5678);
        set_mask(1, 32'h9ABC_DEF0);
        set_mask(2, 32'h0F0F_A5A5);
        set_mask(3, 32'hC3C3_3C3C);
        for (int k = 0; k < 4; k++) begin
            rd(mofs[k], d);
            check("R2 mask readback", d, shadow[k]);
        end

        // R1 R4 R5 R6 R9: walk one source across all positions
        set_mask(0, 32'h5555_5555);
        set_mask(1, 32'hAAAA_AAAA);
        set_mask(2, 32'h0000_FFFF);
        set_mask(3, 32'hFFFF_0000);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            src = 32'd1 << i;
            settle();
            check_all("walk");
        end

        // R6: one source into all four lines
        for (int k = 0; k < 4; k++) set_mask(k, 32'h0000_0100);
        @(negedge clk); src = 32'h0000_0100;
        settle();
        check("R6 all lines together", {28'd0, core_mchk, core_irq}, 32'h0000_000F);

        // R5: all masks zero blocks everything
        for (int k = 0; k < 4; k++) set_mask(k, 32'h0);
        @(negedge clk); src = 32'hFFFF_FFFF;
        settle();
        check("R5 blocked lines", {28'd0, core_mchk, core_irq}, 32'd0);
        rd(8'h20, d);
        check("R9 none active", d, 32'd0);

        // R9 bit 0 alone reads 0, bit 31 reads 31
        set_mask(0, 32'h0000_0001);
        @(negedge clk);
        check_all("prio bit0");
        set_mask(0, 32'h8000_0001);
        @(negedge clk);
        check_all("prio bit31");

        // Pseudo-random sweep over sources and masks
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 96; n++) begin
            for (int k = 0; k < 4; k++) begin
                lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
                set_mask(k, lfsr & ((n % 3 == 0) ? 32'h0000_00FF : 32'hFFFF_FFFF));
            end
            lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
            @(negedge clk); src = lfsr & {lfsr[15:0], lfsr[31:16]};
            settle();
            check_all("sweep");
        end

        // R7: level hold, mask clear timing, source drop timing
        for (int k = 0; k < 4; k++) set_mask(k, 32'h0);
        set_mask(0, 32'h0000_0008);
        @(negedge clk); src = 32'h0000_0008;
        settle();
        repeat (10) @(negedge clk);
        check("R7 held without ack", {31'd0, core_irq[0]}, 32'd1);
        wr(8'h10, 32'h0); shadow[0] = 32'h0;
        check("R4 R7 one edge after mask write still high", {31'd0, core_irq[0]}, 32'd1);
        @(negedge clk);
        check("R4 R7 low after mask clear", {31'd0, core_irq[0]}, 32'd0);
        set_mask(0, 32'h0000_0008);
        @(negedge clk);
        check("R7 re-enabled", {31'd0, core_irq[0]}, 32'd1);
        src = 32'h0;
        repeat (2) @(negedge clk);
        check("R7 still high two edges after drop", {31'd0, core_irq[0]}, 32'd1);
        @(negedge clk);
        check("R7 low three edges after drop", {31'd0, core_irq[0]}, 32'd0);

        // R8: unmapped reads, ignored writes
        set_mask(0, 32'h1111_1111);
        set_mask(1, 32'h2222_2222);
        set_mask(2, 32'h4444_4444);
        set_mask(3, 32'h8888_8888);
        @(negedge clk); src = 32'h0000_00F0;
        foreach (mofs[k]) begin end
        rd(8'h04, d); check("R8 unmapped 0x04", d, 32'd0);
        rd(8'h24, d); check("R8 unmapped 0x24", d, 32'd0);
        rd(8'h11, d); check("R8 unmapped 0x11", d, 32'd0);
        rd(8'hFC, d); check("R8 unmapped 0xFC", d, 32'd0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h12, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        settle();
        for (int k = 0; k < 4; k++) begin
            rd(mofs[k], d);
            check("R8 mask unchanged", d, shadow[k]);
        end
        check_all("R8 after stray writes");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule